// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block supplies the column address for every clock of an SDRAM read or write burst. A controller pulses a start request together with the first column, a burst length code and an ordering choice. From the next clock on, the block steps through the burst one column per clock. It raises a valid flag while a burst is running and a final-beat flag on the closing beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. They walk that block either by counting up with wrap-around or by XOR-ing the beat index into the low bits. A full-page burst walks the whole column space, wraps at the page end and runs until it is stopped. A stop request ends any burst. A new start may arrive on any clock, including mid-burst, and restarts the sequence at once. The column width is 8 bits for a 16-bit-wide memory and 9 bits for an 8-bit-wide one.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `valid_o` and `last_o` are 0 until a start is accepted.
- R2: When `start_i` is high at a rising edge, the next cycle shows `valid_o`=1 and `col_o`=`start_col_i` (beat 0), with the length code and order captured at that edge. This holds on any clock, including the middle of a running burst, which is then abandoned.
- R3: In sequential order (`order_i`=0) with fixed length BL, beat n shows the start column's bits above log2(BL) unchanged and low log2(BL) bits equal to (start + n) mod BL.
- R4: In interleaved order (`order_i`=1) with fixed length BL, beat n shows the start column XOR n.
- R5: Length codes on `blen_i` are 0, 1, 2 and 3 for 1, 2, 4 and 8 beats, and 7 for full page. Codes 4, 5 and 6 act as length 1.
- R6: A fixed burst raises `last_o` only on beat BL-1. `valid_o` falls on the following cycle unless a new start is accepted.
- R7: A full-page burst shows (start + n) mod 2^COL_W on beat n in either order. It never raises `last_o` and runs until stopped.
- R8: `stop_i` high at an edge without `start_i` makes `valid_o` 0 on the next cycle. When `start_i` is high at the same edge, the start wins. A stop while idle has no effect.
- R9: The parameter `COL_W` selects a column width of 8 or 9 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length code |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the running burst |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A burst beat is present |
| last_o | output | 1 | Final beat of a fixed burst |

## Verification
The hardest case to reach from the ports is a full-page burst that crosses the end of the page. Reaching it takes more than a page's worth of consecutive beats with no stop or restart, so the stimulus starts a full-page burst a few columns below the top and holds it for 300 beats before stopping it. A second hard case is a restart or stop landing on each particular beat of a running burst. The bench interrupts an 8-beat burst at every beat offset from 1 to 7.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       blen_i,
  input  logic             order_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);

  logic [COL_W-1:0] base_q, beat_q, mask_q, mask_d, seq_col;
  logic             act_q, fp_q, ilv_q;

  // R5: length code decode into a low-bit mask
  always_comb begin
    case (blen_i)
      3'd1:    mask_d = COL_W'(1);
      3'd2:    mask_d = COL_W'(3);
      3'd3:    mask_d = COL_W'(7);
      3'd7:    mask_d = '1;
      default: mask_d = '0;
    endcase
  end

  assign seq_col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign col_o   = (ilv_q && !fp_q) ? (base_q ^ beat_q) : seq_col;
  assign valid_o = act_q;
  assign last_o  = act_q && !fp_q && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      fp_q   <= 1'b0;
      ilv_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
    end else if (start_i) begin
      act_q  <= 1'b1;
      fp_q   <= (blen_i == 3'd7);
      ilv_q  <= order_i;
      base_q <= start_col_i;
      beat_q <= '0;
      mask_q <= mask_d;
    end else if (act_q) begin
      if (stop_i || last_o) act_q <= 1'b0;
      else                  beat_q <= beat_q + 1'b1;
    end
  end

  initial begin
    a_r9_col_width: assert (COL_W == 8 || COL_W == 9)
      else $error("column width must be 8 or 9");
  end

  a_r1_last_within_burst: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);

  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> valid_o && col_o == $past(start_col_i));

  a_r6_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_o && !start_i |=> !valid_o);

  a_r7_page_step: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && fp_q && !start_i && !stop_i
      |=> valid_o && !last_o && col_o == COL_W'($past(col_o) + 1'b1));

  a_r8_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i && !start_i |=> !valid_o);

endmodule

// File: tb/sim_burst_col_gen.sv
module sim_burst_col_gen;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start_i = 1'b0;
  logic [W-1:0] start_col_i = '0;
  logic [2:0]   blen_i = '0;
  logic         order_i = 1'b0;
  logic         stop_i = 1'b0;
  logic [W-1:0] col_o;
  logic         valid_o, last_o;

  int  n_vec = 0;
  int  n_bad = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  burst_col_gen #(.COL_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .blen_i(blen_i), .order_i(order_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  task automatic chk(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic int blen_of(input int code);
    if (code <= 3) return 1 << code;
    return 1;
  endfunction

  function automatic int exp_col(input int s, input int code, input int ord, input int n);
    int m;
    if (code == 7) return (s + n) % (1 << W);
    m = blen_of(code) - 1;
    if (ord == 1) return s ^ n;
    return (s & ~m & ((1 << W) - 1)) | ((s + n) & m);
  endfunction

  task automatic kick(input int s, input int code, input int ord);
    start_i = 1'b1; start_col_i = W'(s); blen_i = 3'(code); order_i = ord[0];
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic run_fixed(input int s, input int code, input int ord);
    int bl;
    bl = blen_of(code);
    kick(s, code, ord);
    for (int n = 0; n < bl; n++) begin
      chk(ord ? "R4 col" : "R3 col", col_o, exp_col(s, code, ord, n));
      chk("R5 valid", valid_o, 1);
      chk("R6 last", last_o, (n == bl - 1) ? 1 : 0);
      @(negedge clk);
    end
    chk("R6 idle after last", valid_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", valid_o, 0);
    chk("R1 last", last_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", valid_o, 0);

    for (int code = 0; code < 7; code++)
      for (int ord = 0; ord < 2; ord++)
        for (int s = 0; s < (1 << W); s++)
          run_fixed(s, code, ord);

    for (int ord = 0; ord < 2; ord++) begin
      kick(250, 7, ord);
      for (int n = 0; n < 300; n++) begin
        chk("R7 page col", col_o, exp_col(250, 7, ord, n));
        chk("R7 no last", last_o, 0);
        chk("R7 valid", valid_o, 1);
        @(negedge clk);
      end
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8 page stopped", valid_o, 0);
    end

    for (int m = 1; m < 8; m++) begin
      kick(5, 3, 0);
      repeat (m - 1) @(negedge clk);
      chk("R3 before restart", col_o, exp_col(5, 3, 0, m - 1));
      kick(8'h33, 2, 1);
      for (int n = 0; n < 4; n++) begin
        chk("R2 restart col", col_o, exp_col(8'h33, 2, 1, n));
        chk("R2 restart last", last_o, (n == 3) ? 1 : 0);
        @(negedge clk);
      end
      chk("R2 restart ends", valid_o, 0);
    end

    for (int m = 1; m < 8; m++) begin
      kick(9, 3, 1);
      repeat (m - 1) @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      chk("R8 stop mid burst", valid_o, 0);
      @(negedge clk);
      chk("R8 stays idle", valid_o, 0);
    end

    kick(20, 3, 0);
    @(negedge clk);
    stop_i = 1'b1;
    kick(100, 1, 0);
    stop_i = 1'b0;
    chk("R8 start beats stop valid", valid_o, 1);
    chk("R8 start beats stop col", col_o, 100);
    @(negedge clk);
    chk("R8 start beats stop beat1", col_o, 101);
    chk("R8 start beats stop last", last_o, 1);
    @(negedge clk);

    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R8 idle stop", valid_o, 0);
    run_fixed(7, 2, 0);
    chk("R9 width", $bits(col_o), W);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog got 0 expected 1");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule